// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Output-Enable Cell

This block is the serial test port of a memory device. A four-wire serial interface (test clock, mode select, serial input, serial output) drives a sixteen-state controller. The controller selects one of four shift paths: a 3-bit instruction register, a 32-bit identification register, a 1-bit bypass register, or a boundary register whose length is a parameter. Inputs are taken on the rising test-clock edge. The serial output, its enable, the active instruction and the boundary preload stage all change on the falling edge.

The boundary register captures a parallel snapshot of the device pins and shifts it out. At the same time it shifts in a new pattern, which the update state copies into a parallel preload stage. One cell of that stage, at a fixed position, decides whether the functional read-data bus is driven. Under the external-test instruction that cell gates the bus, and a dedicated high-impedance sampling instruction turns the bus off outright. Under every other instruction the core's own enable passes through.

Top module: `jtag_tap_bscan`

## Requirements
- R1: The mode-select and serial-input pins are sampled on the rising test-clock edge. The serial output `tdo` changes only on the falling edge, so its value is the same just before and just after a rising edge.
- R2: Five consecutive rising edges with `tms` high put the controller in its reset state from any state. `tdo_en` is 1 only while the controller is in Shift-DR or Shift-IR, and it is 0 in the reset state and after `rst_n`.
- R3: In Capture-IR the instruction shift stage loads 3'b001. The first three bits shifted out on `tdo` (LSB first) are 1, 0, 0.
- R4: After `rst_n` and whenever the controller sits in its reset state, the active instruction is IDCODE. A data scan under IDCODE returns 32 bits LSB first: bit 0 = 1, bits 11:1 = 11'b00000110100, bits 31:12 = the `DEV_ID` parameter.
- R5: The 3-bit instruction codes are, shifted in LSB first: 000 external test, 001 IDCODE, 010 high-impedance sample, 100 sample/preload, 111 bypass. The unused codes 011, 101 and 110 act as bypass.
- R6: Under bypass the data path is one bit long and captures 0. The first bit out is 0, and each later bit out is the serial input of the previous shift cycle.
- R7: Under external test, high-impedance sample and sample/preload, Capture-DR loads `cap_in` into the boundary register. It shifts with the MSB nearest `tdi` and bit 0 driving `tdo`, so a full scan returns `cap_in` LSB first while the shifted-in word takes its place.
- R8: On the falling edge in Update-DR, and only under the three boundary instructions, `upd_out` takes the boundary shift stage. Under any other instruction an Update-DR leaves `upd_out` unchanged.
- R9: Under high-impedance sample `q_drive_en` is 0 from the Update-IR that loads it until the next Update-IR, including the whole instruction scan in between.
- R10: Under external test, `q_drive_en` equals the output-enable cell `upd_out[OE_POS]` (default 47) and `ext_mode` is 1. Under IDCODE, bypass and sample/preload, `q_drive_en` equals `core_q_oe` and `ext_mode` is 0.
- R11: The output-enable cell `upd_out[OE_POS]` is 1 after `rst_n` and is set to 1 on each falling edge spent in the reset state. Every other preload bit resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Power-up reset, active low, asynchronous |
| tms | input | 1 | Mode select, steers the controller |
| tdi | input | 1 | Serial data into the selected path |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| tdo_en | output | 1 | Serial output enable, high in the two shift states |
| cap_in | input | BSR_LEN | Parallel pin snapshot for the boundary capture |
| upd_out | output | BSR_LEN | Boundary preload stage |
| core_q_oe | input | 1 | Functional read-bus enable from the core |
| q_drive_en | output | 1 | Final read-bus drive enable after test gating |
| ext_mode | output | 1 | High while external test is the active instruction |

## Verification
Captures and shifts land on the rising edge that leaves Capture or Shift. The new instruction, the preload stage and `tdo` change half a period later, on the falling edge in Update-IR, Update-DR or Shift. The bench therefore sets inputs and reads `tdo` 3 ns after each falling edge, rechecks `tdo` 2 ns after the next rising edge, and compares `upd_out`, `q_drive_en` and `ext_mode` only after the falling edge of the relevant update state has passed. The high-impedance hold is also sampled in Exit1-IR, before the following Update-IR, to confirm the bus stays off until that falling edge.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_st_e;

  typedef enum logic [1:0] {PATH_BYP, PATH_ID, PATH_BSR} dr_path_e;

  localparam int unsigned OP_W = 3;
  localparam logic [OP_W-1:0] OP_EXTEST     = 3'b000;
  localparam logic [OP_W-1:0] OP_IDCODE     = 3'b001;
  localparam logic [OP_W-1:0] OP_HIZ_SAMPLE = 3'b010;
  localparam logic [OP_W-1:0] OP_SAMPLE     = 3'b100;
  localparam logic [OP_W-1:0] OP_BYPASS     = 3'b111;
  localparam logic [OP_W-1:0] IR_CAPTURE    = 3'b001;

  localparam int unsigned ID_W  = 32;
  localparam int unsigned DEV_W = 20;
  localparam logic [10:0] MAKER_CODE = 11'b00000110100;

  function automatic tap_st_e tap_next(input tap_st_e s, input logic m);
    case (s)
      ST_RESET:  return m ? ST_RESET  : ST_IDLE;
      ST_IDLE:   return m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: return m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: return m ? ST_EX1_DR : ST_SHF_DR;
      ST_SHF_DR: return m ? ST_EX1_DR : ST_SHF_DR;
      ST_EX1_DR: return m ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: return m ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: return m ? ST_UPD_DR : ST_SHF_DR;
      ST_UPD_DR: return m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: return m ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: return m ? ST_EX1_IR : ST_SHF_IR;
      ST_SHF_IR: return m ? ST_EX1_IR : ST_SHF_IR;
      ST_EX1_IR: return m ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: return m ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: return m ? ST_UPD_IR : ST_SHF_IR;
      default:   return m ? ST_SEL_DR : ST_IDLE;
    endcase
  endfunction

  function automatic dr_path_e op_path(input logic [OP_W-1:0] op);
    case (op)
      OP_EXTEST, OP_HIZ_SAMPLE, OP_SAMPLE: return PATH_BSR;
      OP_IDCODE:                           return PATH_ID;
      default:                             return PATH_BYP;
    endcase
  endfunction

  function automatic logic [ID_W-1:0] make_id(input logic [DEV_W-1:0] dev);
    return {dev, MAKER_CODE, 1'b1};
  endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import jtag_tap_pkg::*;
(
  input  logic    tck,
  input  logic    rst_n,
  input  logic    tms,
  output tap_st_e st
);
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) st <= ST_RESET;
    else        st <= tap_next(st, tms);
  end
endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import jtag_tap_pkg::*;
(
  input  logic            tck,
  input  logic            rst_n,
  input  tap_st_e         st,
  input  logic            tdi,
  output logic [OP_W-1:0] sr,
  output logic [OP_W-1:0] op
);
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)                sr <= IR_CAPTURE;
    else if (st == ST_CAP_IR)  sr <= IR_CAPTURE;
    else if (st == ST_SHF_IR)  sr <= {tdi, sr[OP_W-1:1]};
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n)                op <= OP_IDCODE;
    else if (st == ST_RESET)   op <= OP_IDCODE;
    else if (st == ST_UPD_IR)  op <= sr;
  end
endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import jtag_tap_pkg::*;
#(
  parameter int unsigned      BSR_LEN = 64,
  parameter int unsigned      OE_POS  = 47,
  parameter logic [DEV_W-1:0] DEV_ID  = 20'h1A2B3
)(
  input  logic               tck,
  input  logic               rst_n,
  input  tap_st_e            st,
  input  dr_path_e           path,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] cap_in,
  output logic               byp,
  output logic [ID_W-1:0]    id_sr,
  output logic [BSR_LEN-1:0] bsr_sr,
  output logic [BSR_LEN-1:0] preload
);
  logic do_cap, do_shf, do_upd, in_reset;
  assign do_cap   = (st == ST_CAP_DR);
  assign do_shf   = (st == ST_SHF_DR);
  assign do_upd   = (st == ST_UPD_DR) && (path == PATH_BSR);
  assign in_reset = (st == ST_RESET);

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      byp    <= 1'b0;
      id_sr  <= '0;
      bsr_sr <= '0;
    end else begin
      if (path == PATH_BYP) begin
        if (do_cap)      byp <= 1'b0;
        else if (do_shf) byp <= tdi;
      end
      if (path == PATH_ID) begin
        if (do_cap)      id_sr <= make_id(DEV_ID);
        else if (do_shf) id_sr <= {tdi, id_sr[ID_W-1:1]};
      end
      if (path == PATH_BSR) begin
        if (do_cap)      bsr_sr <= cap_in;
        else if (do_shf) bsr_sr <= {tdi, bsr_sr[BSR_LEN-1:1]};
      end
    end
  end

  // Preload stage, one cell per bit; the output-enable cell presets high.
  for (genvar i = 0; i < BSR_LEN; i++) begin : g_cell
    if (i == OE_POS) begin : g_oe
      always_ff @(negedge tck or negedge rst_n) begin
        if (!rst_n)        preload[i] <= 1'b1;
        else if (in_reset) preload[i] <= 1'b1;
        else if (do_upd)   preload[i] <= bsr_sr[i];
      end
    end else begin : g_plain
      always_ff @(negedge tck or negedge rst_n) begin
        if (!rst_n)      preload[i] <= 1'b0;
        else if (do_upd) preload[i] <= bsr_sr[i];
      end
    end
  end
endmodule

// File: rtl/jtag_tap_bscan.sv
module jtag_tap_bscan
  import jtag_tap_pkg::*;
#(
  parameter int unsigned      BSR_LEN = 64,
  parameter int unsigned      OE_POS  = 47,
  parameter logic [DEV_W-1:0] DEV_ID  = 20'h1A2B3
)(
  input  logic               tck,
  input  logic               rst_n,
  input  logic               tms,
  input  logic               tdi,
  output logic               tdo,
  output logic               tdo_en,
  input  logic [BSR_LEN-1:0] cap_in,
  output logic [BSR_LEN-1:0] upd_out,
  input  logic               core_q_oe,
  output logic               q_drive_en,
  output logic               ext_mode
);
  tap_st_e          st_q;
  logic [OP_W-1:0]  ir_sr, op_q;
  dr_path_e         path_w;
  logic             byp_q;
  logic [ID_W-1:0]  id_q;
  logic [BSR_LEN-1:0] bsr_q, preload_q;
  logic             oe_cell, shifting, tdo_next;

  tap_fsm u_fsm (.tck(tck), .rst_n(rst_n), .tms(tms), .st(st_q));

  tap_ir u_ir (.tck(tck), .rst_n(rst_n), .st(st_q), .tdi(tdi), .sr(ir_sr), .op(op_q));

  assign path_w = op_path(op_q);

  tap_dr #(.BSR_LEN(BSR_LEN), .OE_POS(OE_POS), .DEV_ID(DEV_ID)) u_dr (
    .tck(tck), .rst_n(rst_n), .st(st_q), .path(path_w), .tdi(tdi),
    .cap_in(cap_in), .byp(byp_q), .id_sr(id_q), .bsr_sr(bsr_q), .preload(preload_q)
  );

  assign oe_cell  = preload_q[OE_POS];
  assign shifting = (st_q == ST_SHF_DR) || (st_q == ST_SHF_IR);

  always_comb begin
    if (st_q == ST_SHF_IR) tdo_next = ir_sr[0];
    else begin
      case (path_w)
        PATH_ID:  tdo_next = id_q[0];
        PATH_BSR: tdo_next = bsr_q[0];
        default:  tdo_next = byp_q;
      endcase
    end
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo    <= tdo_next;
      tdo_en <= shifting;
    end
  end

  always_comb begin
    case (op_q)
      OP_EXTEST:     q_drive_en = oe_cell;
      OP_HIZ_SAMPLE: q_drive_en = 1'b0;
      default:       q_drive_en = core_q_oe;
    endcase
  end

  assign ext_mode = (op_q == OP_EXTEST);
  assign upd_out  = preload_q;
endmodule

// File: rtl/tap_checker.sv
module tap_checker
  import jtag_tap_pkg::*;
(
  input logic            tck,
  input logic            rst_n,
  input logic            tms,
  input tap_st_e         st,
  input logic [OP_W-1:0] op,
  input logic [OP_W-1:0] ir_sr,
  input dr_path_e        path,
  input logic            byp,
  input logic            tdo_en,
  input logic            q_drive_en,
  input logic            oe_cell
);
  logic [2:0] ones;
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)    ones <= 3'd0;
    else if (!tms) ones <= 3'd0;
    else if (ones != 3'd7) ones <= ones + 3'd1;
  end

  AST_FIVE_ONES_RESET: assert property (@(posedge tck) disable iff (!rst_n)
    (ones >= 3'd5) |-> (st == ST_RESET)); // R2
  AST_TDO_QUIET_IN_RESET: assert property (@(posedge tck) disable iff (!rst_n)
    (st == ST_RESET) |-> !tdo_en); // R2
  AST_IR_CAPTURE_PATTERN: assert property (@(posedge tck) disable iff (!rst_n)
    (st == ST_CAP_IR) |=> (ir_sr[1:0] == 2'b01)); // R3
  AST_IDCODE_IN_RESET: assert property (@(posedge tck) disable iff (!rst_n)
    (st == ST_RESET && $past(st) == ST_RESET) |-> (op == OP_IDCODE)); // R4
  AST_BYPASS_CAPTURES_ZERO: assert property (@(posedge tck) disable iff (!rst_n)
    (st == ST_CAP_DR && path == PATH_BYP) |=> !byp); // R6
  AST_HIZ_SAMPLE_OFF: assert property (@(posedge tck) disable iff (!rst_n)
    (op == OP_HIZ_SAMPLE) |-> !q_drive_en); // R9
  AST_OE_CELL_PRESET: assert property (@(posedge tck) disable iff (!rst_n)
    (st == ST_RESET && $past(st) == ST_RESET) |-> oe_cell); // R11
endmodule

bind jtag_tap_bscan tap_checker u_chk (
  .tck(tck), .rst_n(rst_n), .tms(tms), .st(st_q), .op(op_q), .ir_sr(ir_sr),
  .path(path_w), .byp(byp_q), .tdo_en(tdo_en), .q_drive_en(q_drive_en), .oe_cell(oe_cell)
);

// File: tb/tb_jtag_tap_bscan.sv
module tb_jtag_tap_bscan;
  localparam int N = 64;
  localparam int OE = 47;
  localparam logic [19:0] DEV = 20'h1A2B3;
  localparam logic [31:0] EXP_ID = {DEV, 11'b00000110100, 1'b1};

  logic tck = 0, rst_n = 0, tms = 1, tdi = 0, core_q_oe = 1;
  logic tdo, tdo_en, q_drive_en, ext_mode;
  logic [N-1:0] cap_in = '0, upd_out;
  int n_vec = 0, n_err = 0;
  logic r1_bad = 0, en_seen = 0;
  logic [N-1:0] exp_pre;

  always #10 tck = ~tck;

  jtag_tap_bscan #(.BSR_LEN(N), .OE_POS(OE), .DEV_ID(DEV)) dut (
    .tck(tck), .rst_n(rst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
    .cap_in(cap_in), .upd_out(upd_out), .core_q_oe(core_q_oe),
    .q_drive_en(q_drive_en), .ext_mode(ext_mode)
  );

  // {op[2:0], oe bit shifted in, path (0 bypass,1 id,2 boundary), drive after update, ext_mode}
  localparam logic [7:0] VEC [10] = '{
    {3'b100, 1'b0, 2'd2, 1'b1, 1'b0},
    {3'b000, 1'b1, 2'd2, 1'b1, 1'b1},
    {3'b000, 1'b0, 2'd2, 1'b0, 1'b1},
    {3'b010, 1'b1, 2'd2, 1'b0, 1'b0},
    {3'b001, 1'b0, 2'd1, 1'b1, 1'b0},
    {3'b111, 1'b0, 2'd0, 1'b1, 1'b0},
    {3'b011, 1'b0, 2'd0, 1'b1, 1'b0},
    {3'b101, 1'b1, 2'd0, 1'b1, 1'b0},
    {3'b110, 1'b0, 2'd0, 1'b1, 1'b0},
    {3'b100, 1'b1, 2'd2, 1'b1, 1'b0}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input logic m, input logic d, output logic o);
    @(negedge tck); #3;
    tms = m; tdi = d; o = tdo; en_seen = tdo_en;
    @(posedge tck); #2;
    if (tdo !== o) r1_bad = 1;
  endtask

  task automatic load_ir(input logic [2:0] op, output logic [2:0] cap);
    logic j;
    tick(1, 0, j); tick(1, 0, j); tick(0, 0, j); tick(0, 0, j);
    for (int i = 0; i < 3; i++) tick(i == 2, op[i], cap[i]);
    tick(1, 0, j); tick(0, 0, j);
  endtask

  task automatic scan_dr(input logic [N-1:0] din, output logic [N-1:0] dout, output logic en0);
    logic j;
    tick(1, 0, j); tick(0, 0, j); tick(0, 0, j);
    for (int i = 0; i < N; i++) begin
      tick(i == N - 1, din[i], dout[i]);
      if (i == 0) en0 = en_seen;
    end
    tick(1, 0, j); tick(0, 0, j);
  endtask

  function automatic logic [N-1:0] pat(input int k, input logic oe);
    logic [N-1:0] p;
    p = {32'h0F0F1234 ^ k, 32'h80017E00 + k};
    p[OE] = oe;
    return p;
  endfunction

  function automatic logic [N-1:0] capv(input int k);
    return {32'hC3A50000 + k, 32'h1F2E3D4C ^ (k << 8)};
  endfunction

  initial begin
    repeat (200000) @(posedge tck);
    n_vec++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    logic [2:0] ircap;
    logic [N-1:0] dout, expv;
    logic en0, j;
    repeat (3) @(posedge tck);
    #2 rst_n = 1;
    // reset state
    check(tdo_en === 1'b0, "R2 tdo_en after reset", 64'(tdo_en), 64'd0);
    check(upd_out === (64'd1 << OE), "R11 preload after reset", upd_out, 64'd1 << OE);
    check(q_drive_en === 1'b1 && ext_mode === 1'b0, "R10 drive under reset IDCODE",
          {q_drive_en, ext_mode}, 64'b10);
    exp_pre = 64'd1 << OE;
    tick(0, 0, j);
    check(tdo_en === 1'b0, "R2 tdo_en in idle", 64'(tdo_en), 64'd0);
    // IDCODE active without loading an instruction
    scan_dr(pat(99, 1), dout, en0);
    check(dout[31:0] === EXP_ID, "R4 IDCODE after reset", dout[31:0], EXP_ID);
    check(en0 === 1'b1, "R2 tdo_en in Shift-DR", 64'(en0), 64'd1);

    // vector walk
    for (int k = 0; k < 10; k++) begin
      logic [7:0] v;
      logic [N-1:0] din;
      v = VEC[k];
      cap_in = capv(k);
      din = pat(k, v[4]);
      load_ir(v[7:5], ircap);
      check(ircap === 3'b001, "R3 IR capture", 64'(ircap), 64'd1);
      scan_dr(din, dout, en0);
      case (v[3:2])
        2'd2: check(dout === cap_in, "R7 boundary capture/shift", dout, cap_in);
        2'd1: check(dout[31:0] === EXP_ID, "R4 R5 IDCODE decode", dout[31:0], EXP_ID);
        default: begin
          expv = {din[N-2:0], 1'b0};
          check(dout === expv, "R5 R6 bypass path", dout, expv);
        end
      endcase
      if (v[3:2] == 2'd2) exp_pre = din;
      check(upd_out === exp_pre, "R8 preload update", upd_out, exp_pre);
      check(q_drive_en === v[1], "R9 R10 drive enable", 64'(q_drive_en), 64'(v[1]));
      check(ext_mode === v[0], "R10 ext_mode", 64'(ext_mode), 64'(v[0]));
    end

    // core enable passes through under IDCODE
    load_ir(3'b001, ircap);
    core_q_oe = 0; #1;
    check(q_drive_en === 1'b0, "R10 core enable low passes", 64'(q_drive_en), 64'd0);
    core_q_oe = 1; #1;
    check(q_drive_en === 1'b1, "R10 core enable high passes", 64'(q_drive_en), 64'd1);

    // high-impedance sample holds until the next Update-IR
    load_ir(3'b010, ircap);
    check(q_drive_en === 1'b0, "R9 bus off after load", 64'(q_drive_en), 64'd0);
    tick(1, 0, j); tick(1, 0, j); tick(0, 0, j); tick(0, 0, j);
    tick(0, 0, j); tick(0, 0, j); tick(1, 0, j);
    check(q_drive_en === 1'b0, "R9 bus off before Update-IR", 64'(q_drive_en), 64'd0);
    tick(1, 0, j); tick(0, 0, j);
    check(q_drive_en === exp_pre[OE] && ext_mode === 1'b1, "R10 EXTEST after update",
          {q_drive_en, ext_mode}, {exp_pre[OE], 1'b1});

    // EXTEST with OE cell cleared, then five TMS-high returns to reset
    scan_dr(pat(50, 0), dout, en0);
    exp_pre = pat(50, 0);
    check(q_drive_en === 1'b0, "R10 OE cell 0 turns bus off", 64'(q_drive_en), 64'd0);
    for (int i = 0; i < 5; i++) tick(1, 0, j);
    check(tdo_en === 1'b0, "R2 tdo_en after five TMS high", 64'(tdo_en), 64'd0);
    check(ext_mode === 1'b0 && q_drive_en === 1'b1, "R2 R4 instruction reset by TMS",
          {ext_mode, q_drive_en}, 64'b01);
    exp_pre[OE] = 1'b1;
    check(upd_out === exp_pre, "R11 OE cell preset in reset state", upd_out, exp_pre);
    tick(0, 0, j);
    scan_dr(pat(51, 0), dout, en0);
    check(dout[31:0] === EXP_ID, "R4 IDCODE after TMS reset", dout[31:0], EXP_ID);

    check(!r1_bad, "R1 tdo stable across rising edge", 64'(r1_bad), 64'd0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule